// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer with Offset Calibration

This block controls an external successive-approximation converter: a comparator and a DAC. Software programs two control registers through a small register port. It selects an input channel, sets an acquisition time and a conversion clock, and then sets a start bit. The sequencer waits for the acquisition time. It then runs a 10-bit binary search, MSB first, one trial per conversion-clock period. It drives the trial code to the DAC and reads the comparator's decision back. At the end it clears the start bit, raises a done flag, and exposes the result as a high byte and a low byte. Software selects right- or left-justified form for the result.

Setting the calibration-arm bit changes what the next start does. That start runs a dummy conversion with the channel mux disconnected. The outcome is kept as an offset, and the arm bit clears itself. Every later ordinary result has the offset subtracted, floored at zero. The conversion clock period (TAD) is derived from the system clock by a power-of-two divider.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, every register reads zero: control (address 0), configuration (address 1), result high (address 2) and result low (address 3). In the same state, `irq_done`, `mux_connect` and `dac_code` are 0.
- R2: The start bit is bit 1 of the control register. Writing it as 1 starts a conversion only if the enable bit (bit 0) already held 1 before the write. Otherwise the start bit reads back 0 and no conversion runs.
- R3: The search runs over 10 steps, MSB first. During each step `dac_code` shows the bits kept so far plus the current trial bit. A trial bit is kept when `cmp_in` is 1 at the last clock of the step. Outside the steps, `dac_code` is 0.
- R4: TAD is 2 << S system clocks, where S is configuration bits 2:0. Configuration bits 5:3 select the acquisition wait. Codes 1 to 7 give 2, 4, 6, 8, 12, 16 or 20 TAD. After the wait come 10 steps of one TAD each.
- R5: With acquisition code 0, the search begins INSN_CLKS (4) system clocks after the start is accepted.
- R6: The final step clears the start bit and sets `irq_done` on the same clock edge. `irq_done` stays set until the next start is accepted, which clears it.
- R7: A start taken while calibration-arm (control bit 7) is set runs with `mux_connect` low throughout. It stores the outcome as the offset and leaves the result registers unchanged. It also clears calibration-arm when it finishes.
- R8: During an ordinary conversion, `mux_connect` is high from the accepting edge to the finishing edge. `mux_sel` always equals control bits 5:2.
- R9: Each ordinary result is stored as max(raw − offset, 0). The offset is 0 from reset until a calibration run completes.
- R10: Configuration bit 7 selects the result format. With bit 7 = 1, the high byte holds result bits 9:8 in its low two bits and the low byte holds bits 7:0. With bit 7 = 0, the high byte holds bits 9:2 and the low byte holds bits 1:0 in its top two bits.
- R11: Writes to the control and configuration registers are ignored while a conversion is in progress.
- R12: Control reads back as {arm, 0, channel[3:0], start, enable}. Configuration reads back as {format, 0, acq[2:0], clock-select[2:0]}. Bit 6 of each always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 configuration, 2 result high, 3 result low) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| cmp_in | input | 1 | Comparator decision: input at or above DAC level |
| dac_code | output | 10 | Trial code to the DAC |
| mux_sel | output | 4 | Channel mux select |
| mux_connect | output | 1 | Channel mux connected to the sample node |
| irq_done | output | 1 | Conversion-complete flag |

## Verification
The bench uses the default parameters: a 10-bit result and a 4-clock delay for acquisition code 0. It programs clock selects 0 and 1, so one TAD is 2 or 4 clocks. Even the longest acquisition setting then completes within about 120 cycles. This lets the bench exercise, cycle by cycle, every trial code, the zero-code delay, the 20-TAD wait, calibration and saturated subtraction. Analog inputs at zero, mid-scale and beyond full scale cover both ends of the search.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int CSEL_W = 3;
  localparam int ASEL_W = 3;
  localparam int CHAN_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_STEP = 2'd2
  } phase_e;

  typedef struct packed {
    logic              fmt_right;
    logic [ASEL_W-1:0] acq;
    logic [CSEL_W-1:0] csel;
  } cfg_t;

  // acquisition code to number of conversion-clock periods
  function automatic int unsigned acq_tads(input logic [ASEL_W-1:0] code);
    int unsigned n;
    case (code)
      3'd1:    n = 2;
      3'd2:    n = 4;
      3'd3:    n = 6;
      3'd4:    n = 8;
      3'd5:    n = 12;
      3'd6:    n = 16;
      3'd7:    n = 20;
      default: n = 0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sar_regs.sv
module sar_regs
  import sar_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              busy,
  input  logic              finish,
  input  logic              cal_done,
  input  logic [RES_W-1:0]  result,
  output logic              start,
  output logic              go,
  output logic              cal_arm,
  output logic [CHAN_W-1:0] chan,
  output cfg_t              cfg,
  output logic              irq
);

  localparam int PAD = 16 - RES_W;

  logic              cal_q, cal_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic              en_q, en_d;
  logic              go_q, go_d;
  logic              irq_q, irq_d;
  cfg_t              cfg_q, cfg_d;
  logic              wr_ctrl, wr_cfg, upd_en;
  logic [15:0]       right16, left16;
  logic              unused_bit6;

  assign unused_bit6 = wdata[6];
  assign wr_ctrl = we && (addr == 2'd0) && !busy;
  assign wr_cfg  = we && (addr == 2'd1) && !busy;
  assign start   = wr_ctrl && wdata[1] && en_q;
  assign upd_en  = wr_ctrl || wr_cfg || finish;

  always_comb begin
    cal_d  = cal_q;
    chan_d = chan_q;
    en_d   = en_q;
    go_d   = go_q;
    irq_d  = irq_q;
    cfg_d  = cfg_q;
    if (wr_ctrl) begin
      cal_d  = wdata[7];
      chan_d = wdata[5:2];
      en_d   = wdata[0];
    end
    if (wr_cfg) begin
      cfg_d.fmt_right = wdata[7];
      cfg_d.acq       = wdata[5:3];
      cfg_d.csel      = wdata[2:0];
    end
    if (start) begin
      go_d  = 1'b1;
      irq_d = 1'b0;
    end
    if (finish) begin
      go_d  = 1'b0;
      irq_d = 1'b1;
      if (cal_done) cal_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q  <= 1'b0;
      chan_q <= '0;
      en_q   <= 1'b0;
      go_q   <= 1'b0;
      irq_q  <= 1'b0;
      cfg_q  <= '0;
    end else if (upd_en) begin
      cal_q  <= cal_d;
      chan_q <= chan_d;
      en_q   <= en_d;
      go_q   <= go_d;
      irq_q  <= irq_d;
      cfg_q  <= cfg_d;
    end
  end

  assign right16 = 16'(result);
  assign left16  = right16 << PAD;

  always_comb begin
    unique case (addr)
      2'd0: rdata = {cal_q, 1'b0, chan_q, go_q, en_q};
      2'd1: rdata = {cfg_q.fmt_right, 1'b0, cfg_q.acq, cfg_q.csel};
      2'd2: rdata = cfg_q.fmt_right ? right16[15:8] : left16[15:8];
      default: rdata = cfg_q.fmt_right ? right16[7:0] : left16[7:0];
    endcase
  end

  assign go      = go_q;
  assign cal_arm = cal_q;
  assign chan    = chan_q;
  assign cfg     = cfg_q;
  assign irq     = irq_q;

  AST_GO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_q) |-> $past(en_q)); // R2

  AST_IRQ_CLR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !irq_q); // R6

  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(cfg_q)); // R11

endmodule

// File: rtl/sar_timing.sv
module sar_timing
  import sar_pkg::*;
#(
  parameter int INSN_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ASEL_W-1:0] acq,
  input  logic [CSEL_W-1:0] csel,
  input  logic              last_bit,
  output logic              busy,
  output logic              step_phase,
  output logic              conv_enter,
  output logic              step_end,
  output logic              finish
);

  localparam int DIV_MAX  = 2 << ((1 << CSEL_W) - 1);
  localparam int WAIT_MAX = (20 * DIV_MAX > INSN_CLKS) ? 20 * DIV_MAX : INSN_CLKS;
  localparam int TMR_W    = $clog2(WAIT_MAX + 1);

  phase_e           ph_q, ph_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [TMR_W-1:0] div, wait_len;
  logic             tmr_one, upd_en;

  assign div      = TMR_W'(2) << csel;
  assign wait_len = (acq == '0) ? TMR_W'(INSN_CLKS)
                                : TMR_W'(acq_tads(acq)) * div;
  assign tmr_one  = (tmr_q == TMR_W'(1));

  always_comb begin
    ph_d  = ph_q;
    tmr_d = tmr_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_ACQ;
          tmr_d = wait_len;
        end
      end
      PH_ACQ: begin
        if (tmr_one) begin
          ph_d  = PH_STEP;
          tmr_d = div;
        end else begin
          tmr_d = tmr_q - TMR_W'(1);
        end
      end
      PH_STEP: begin
        if (tmr_one) begin
          if (last_bit) ph_d = PH_IDLE;
          tmr_d = div;
        end else begin
          tmr_d = tmr_q - TMR_W'(1);
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign upd_en = start || (ph_q != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      tmr_q <= '0;
    end else if (upd_en) begin
      ph_q  <= ph_d;
      tmr_q <= tmr_d;
    end
  end

  assign busy       = (ph_q != PH_IDLE);
  assign step_phase = (ph_q == PH_STEP);
  assign conv_enter = (ph_q == PH_ACQ) && tmr_one;
  assign step_end   = (ph_q == PH_STEP) && tmr_one;
  assign finish     = step_end && last_bit;

  AST_WAIT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ph_q == PH_ACQ) && (tmr_q != '0)); // R4

  AST_STEP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    conv_enter |=> (ph_q == PH_STEP) && (tmr_q == $past(div))); // R4

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_enter,
  input  logic             step_end,
  input  logic             step_phase,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             last_bit,
  output logic [RES_W-1:0] final_code
);

  localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] acc_q, acc_d;
  logic [RES_W-1:0] trial_q, trial_d;
  logic [RES_W-1:0] keep;
  logic             upd_en;

  assign keep       = cmp_in ? trial_q : '0;
  assign final_code = acc_q | keep;
  assign last_bit   = trial_q[0];
  assign upd_en     = conv_enter || step_end;

  always_comb begin
    acc_d   = acc_q;
    trial_d = trial_q;
    if (conv_enter) begin
      acc_d   = '0;
      trial_d = MSB;
    end else if (step_end) begin
      acc_d   = acc_q | keep;
      trial_d = trial_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      trial_q <= '0;
    end else if (upd_en) begin
      acc_q   <= acc_d;
      trial_q <= trial_d;
    end
  end

  assign dac_code = step_phase ? (acc_q | trial_q) : '0;

  AST_ONE_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    step_phase |-> ($countones(trial_q) == 1)); // R3

  AST_KEPT_BITS_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (step_end && !conv_enter) |=> ((acc_q & $past(acc_q)) == $past(acc_q))); // R3

endmodule

// File: rtl/sar_offset.sv
module sar_offset #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             finish,
  input  logic             cal_run,
  input  logic [RES_W-1:0] raw,
  output logic [RES_W-1:0] result
);

  logic [RES_W-1:0] off_q, off_d;
  logic [RES_W-1:0] res_q, res_d;
  logic [RES_W-1:0] corrected;

  assign corrected = (raw > off_q) ? (raw - off_q) : '0;

  always_comb begin
    off_d = off_q;
    res_d = res_q;
    if (finish) begin
      if (cal_run) off_d = raw;
      else         res_d = corrected;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      res_q <= '0;
    end else if (finish) begin
      off_q <= off_d;
      res_q <= res_d;
    end
  end

  assign result = res_q;

  AST_RES_NOT_ABOVE_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !cal_run) |=> (res_q <= $past(raw))); // R9

  AST_CAL_KEEPS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && cal_run) |=> $stable(res_q)); // R7

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int INSN_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cmp_in,
  output logic [RES_W-1:0]  dac_code,
  output logic [CHAN_W-1:0] mux_sel,
  output logic              mux_connect,
  output logic              irq_done
);

  logic [1:0]       rs_q;
  logic             rst_ns;
  logic             start, go, cal_arm, busy, step_phase;
  logic             conv_enter, step_end, finish, last_bit;
  logic             cal_run_q, cal_run_d;
  logic [RES_W-1:0] final_code, result;
  cfg_t             cfg;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  sar_regs #(.RES_W(RES_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_ns),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .busy     (busy),
    .finish   (finish),
    .cal_done (cal_run_q),
    .result   (result),
    .start    (start),
    .go       (go),
    .cal_arm  (cal_arm),
    .chan     (mux_sel),
    .cfg      (cfg),
    .irq      (irq_done)
  );

  sar_timing #(.INSN_CLKS(INSN_CLKS)) u_timing (
    .clk        (clk),
    .rst_n      (rst_ns),
    .start      (start),
    .acq        (cfg.acq),
    .csel       (cfg.csel),
    .last_bit   (last_bit),
    .busy       (busy),
    .step_phase (step_phase),
    .conv_enter (conv_enter),
    .step_end   (step_end),
    .finish     (finish)
  );

  sar_engine #(.RES_W(RES_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_ns),
    .conv_enter (conv_enter),
    .step_end   (step_end),
    .step_phase (step_phase),
    .cmp_in     (cmp_in),
    .dac_code   (dac_code),
    .last_bit   (last_bit),
    .final_code (final_code)
  );

  sar_offset #(.RES_W(RES_W)) u_offset (
    .clk     (clk),
    .rst_n   (rst_ns),
    .finish  (finish),
    .cal_run (cal_run_q),
    .raw     (final_code),
    .result  (result)
  );

  // the arm bit written together with the start still counts
  assign cal_run_d = reg_wdata[7];

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)    cal_run_q <= 1'b0;
    else if (start) cal_run_q <= cal_run_d;
  end

  assign mux_connect = busy && !cal_run_q;

  AST_GO_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rst_ns)
    go == busy); // R6

  AST_CAL_AUTOCLEAR: assert property (@(posedge clk) disable iff (!rst_ns)
    (finish && cal_run_q) |=> !cal_arm); // R7

  AST_IRQ_WITH_FINISH: assert property (@(posedge clk) disable iff (!rst_ns)
    finish |=> (irq_done && !go)); // R6

endmodule

// File: tb/test_sar_adc_seq.sv
module test_sar_adc_seq;

  logic       clk;
  logic       rst_n;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic [3:0] mux_sel;
  logic       mux_connect;
  logic       irq_done;

  int total = 0;
  int bad   = 0;
  int vin [16];
  int voff = 0;
  bit finished = 0;

  sar_adc_seq i_sar_adc_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .cmp_in      (cmp_in),
    .dac_code    (dac_code),
    .mux_sel     (mux_sel),
    .mux_connect (mux_connect),
    .irq_done    (irq_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // analog front end model
  assign cmp_in = mux_connect ? (vin[mux_sel] >= int'(dac_code))
                              : (voff >= int'(dac_code));

  // ---------------- behavioural reference ----------------
  int m_busy, m_wait, m_idx, m_sc, m_acc, m_cal, m_chan, m_en, m_calrun;
  int m_fmt, m_acq, m_csel, m_off, m_res, m_irq;

  function automatic int tad_of(int cs);
    return 2 << cs;
  endfunction

  function automatic int acq_of(int a);
    int t [8] = '{0, 2, 4, 6, 8, 12, 16, 20};
    return t[a];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_wait = 0; m_idx = 0; m_sc = 0; m_acc = 0; m_cal = 0;
      m_chan = 0; m_en = 0; m_calrun = 0; m_fmt = 0; m_acq = 0; m_csel = 0;
      m_off = 0; m_res = 0; m_irq = 0;
    end else if (m_busy != 0) begin
      if (m_wait > 0) begin
        m_wait--;
        if (m_wait == 0) begin
          m_idx = 9;
          m_sc  = tad_of(m_csel);
        end
      end else begin
        m_sc--;
        if (m_sc == 0) begin
          int code, v;
          code = m_acc | (1 << m_idx);
          v = (m_calrun != 0) ? voff : vin[m_chan];
          if (v >= code) m_acc = code;
          if (m_idx == 0) begin
            m_busy = 0;
            m_irq  = 1;
            if (m_calrun != 0) begin
              m_off = m_acc;
              m_cal = 0;
            end else begin
              m_res = (m_acc > m_off) ? m_acc - m_off : 0;
            end
          end else begin
            m_idx--;
            m_sc = tad_of(m_csel);
          end
        end
      end
    end else if (reg_we) begin
      if (reg_addr == 2'd0) begin
        int st;
        st = (reg_wdata[1] && m_en != 0) ? 1 : 0;
        m_cal  = reg_wdata[7];
        m_chan = int'(reg_wdata[5:2]);
        m_en   = reg_wdata[0];
        if (st != 0) begin
          m_busy   = 1;
          m_irq    = 0;
          m_calrun = reg_wdata[7];
          m_acc    = 0;
          m_wait   = (m_acq == 0) ? 4 : acq_of(m_acq) * tad_of(m_csel);
        end
      end else if (reg_addr == 2'd1) begin
        m_fmt  = reg_wdata[7];
        m_acq  = int'(reg_wdata[5:3]);
        m_csel = int'(reg_wdata[2:0]);
      end
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int e_dac;
      e_dac = (m_busy != 0 && m_wait == 0) ? (m_acc | (1 << m_idx)) : 0;
      total++;
      if (int'(dac_code) != e_dac) begin
        bad++;
        $display("FAIL R3 dac_code got=%0d exp=%0d", dac_code, e_dac);
      end
      total++;
      if (int'(irq_done) != m_irq) begin
        bad++;
        $display("FAIL R6 irq_done got=%0d exp=%0d", irq_done, m_irq);
      end
      total++;
      if (int'(mux_connect) != ((m_busy != 0 && m_calrun == 0) ? 1 : 0) ||
          int'(mux_sel) != m_chan) begin
        bad++;
        $display("FAIL R8 mux got=%0d/%0d exp=%0d/%0d", mux_connect, mux_sel,
                 (m_busy != 0 && m_calrun == 0), m_chan);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!irq_done && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  // ---------------- stimulus ----------------
  initial begin
    int v, n;
    foreach (vin[i]) vin[i] = 0;
    vin[3] = 500;
    vin[5] = 20;
    vin[7] = 2000;
    rst_n = 1'b0;
    reg_we = 1'b0;
    reg_addr = 2'd0;
    reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 cfg", v, 0);
    rd(2'd2, v); check("R1 res hi", v, 0);
    rd(2'd3, v); check("R1 res lo", v, 0);
    check("R1 irq", int'(irq_done), 0);

    // R2 start while disabled is ignored
    wr(2'd0, 8'h02);
    rd(2'd0, v); check("R2 go ignored", v, 0);
    repeat (40) @(negedge clk);
    check("R2 no irq", int'(irq_done), 0);

    // R12 bit 6 reads 0; enable + channel 3
    wr(2'd1, 8'hC8);
    rd(2'd1, v); check("R12 cfg readback", v, 8'h88);
    wr(2'd0, 8'h4D);
    rd(2'd0, v); check("R12 ctrl readback", v, 8'h0D);

    // R4 2 TAD acquisition, TAD = 2 clocks
    wr(2'd0, 8'h0F);
    rd(2'd0, v); check("R2 go set", v, 8'h0F);
    wait_done(n);
    check("R4 cycles acq1", n, 4 + 20);
    rd(2'd0, v); check("R6 go cleared", v, 8'h0D);
    rd(2'd2, v); check("R3 hi 500", v, 8'h01);
    rd(2'd3, v); check("R3 lo 500", v, 8'hF4);

    // R5 zero acquisition code: instruction delay, TAD = 4
    wr(2'd1, 8'h81);
    wr(2'd0, 8'h0F);
    check("R6 irq cleared on start", int'(irq_done), 0);
    wait_done(n);
    check("R5 cycles acq0", n, 4 + 40);

    // R4 20 TAD acquisition
    wr(2'd1, 8'hB9);
    wr(2'd0, 8'h0F);
    wait_done(n);
    check("R4 cycles acq7", n, 80 + 40);

    // R11 writes during conversion ignored
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    wait_done(n);
    rd(2'd1, v); check("R11 cfg kept", v, 8'hB9);
    rd(2'd0, v); check("R11 ctrl kept", v, 8'h0D);

    // R7 calibration run
    voff = 37;
    wr(2'd1, 8'h88);
    wr(2'd0, 8'h8F);
    repeat (3) @(negedge clk);
    check("R7 mux off in cal", int'(mux_connect), 0);
    wait_done(n);
    rd(2'd0, v); check("R7 arm cleared", v, 8'h0D);
    rd(2'd2, v); check("R7 res hi kept", v, 8'h01);
    rd(2'd3, v); check("R7 res lo kept", v, 8'hF4);

    // R9 corrected results
    wr(2'd0, 8'h0F);
    wait_done(n);
    rd(2'd2, v); check("R9 hi 463", v, 8'h01);
    rd(2'd3, v); check("R9 lo 463", v, 8'hCF);
    wr(2'd0, 8'h17);
    wait_done(n);
    rd(2'd2, v); check("R9 sat hi", v, 0);
    rd(2'd3, v); check("R9 sat lo", v, 0);
    wr(2'd0, 8'h1F);
    wait_done(n);
    rd(2'd3, v); check("R9 full scale lo", v, 8'hDA);

    // R10 left-justified view of 986
    wr(2'd1, 8'h08);
    rd(2'd2, v); check("R10 left hi", v, 8'hF6);
    rd(2'd3, v); check("R10 left lo", v, 8'h80);
    wr(2'd1, 8'h88);
    rd(2'd2, v); check("R10 right hi", v, 8'h03);

    repeat (5) @(negedge clk);
    summary();
  end

endmodule